// File: doc/BRIEF.md
# ADC Conversion Sequence Trigger Controller

This block decides when an analog-to-digital converter begins a conversion sequence. A sequence can be launched by a software start strobe, or by an external trigger pin. The trigger pin is picked from a bank of input channels. The external trigger can be edge sensitive or level sensitive, and a polarity input chooses its active sense. A scan option keeps software-launched sequences running back to back. The converter reports the end of each sequence with a one-cycle completion pulse. The controller answers with a one-cycle start pulse and a busy indication.

The selected trigger pin passes through a synchronizer. Edges are detected on the synchronized value. In edge mode, an active edge that arrives while a sequence is still running is not queued. It sets a sticky overrun flag, which software clears with a write-one-to-clear strobe. In level mode, the trigger going inactive and active again during a sequence is not counted as an overrun. If the trigger is still active when a sequence completes, the next sequence starts at once.

Top module: `adc_seq_trigger`

## Requirements
- R1: After reset, `seq_start`, `busy` and `ovr_flag` are 0, and the trigger source is channel DEFAULT_CH (7).
- R2: With `trig_en`=0 and `scan_mode`=0, a `sw_start` pulse while idle makes `seq_start` high for exactly one cycle, in the cycle after the strobe. `busy` then stays high until the `seq_done` cycle and is low in the cycle after it, and no further sequence follows.
- R3: With `trig_en`=0 and `scan_mode`=1, a software-launched run restarts in the cycle after each `seq_done`. It stops after the sequence during which `scan_mode` is cleared.
- R4: A `sw_start` that arrives while a sequence is busy is ignored.
- R5: With `trig_en`=1 and `trig_level`=0, each synchronized active edge seen while idle starts exactly one sequence. The active edge is rising for `trig_pol`=1 and falling for `trig_pol`=0. `seq_start` rises SYNC_STAGES+1 clocks after the pin changes.
- R6: In edge mode, an active edge that arrives while a sequence runs (and not in its `seq_done` cycle) sets `ovr_flag` and starts no sequence.
- R7: With `trig_en`=1 and `trig_level`=1, sequences repeat while the synchronized trigger is at its active level (high for `trig_pol`=1, low for `trig_pol`=0). When the trigger is still active at `seq_done`, `seq_start` follows in the next cycle.
- R8: In level mode, `ovr_flag` is never set, even when the trigger toggles during a sequence.
- R9: While `trig_en`=1, `sw_start` has no effect.
- R10: `ovr_flag` stays set until an `ovr_clr` cycle. When an overrun and `ovr_clr` fall in the same cycle, the flag ends up set.
- R11: A `sel_wr` cycle with `sel_data` below NUM_CH makes `trig_in[sel_data]` the trigger source. Edges on the other channels are then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_en | input | 1 | 1 = external trigger launches sequences |
| trig_level | input | 1 | 1 = level sensitive, 0 = edge sensitive |
| trig_pol | input | 1 | 1 = rising edge / high level, 0 = falling edge / low level |
| scan_mode | input | 1 | Continuous software-launched sequences |
| sw_start | input | 1 | Software start strobe |
| sel_wr | input | 1 | Load trigger source channel |
| sel_data | input | CH_W | Trigger source channel index |
| trig_in | input | NUM_CH | Candidate trigger pins |
| seq_done | input | 1 | Sequence-complete pulse from the converter |
| ovr_clr | input | 1 | Write-one-to-clear for the overrun flag |
| seq_start | output | 1 | One-cycle sequence start pulse |
| busy | output | 1 | A sequence is in progress |
| ovr_flag | output | 1 | Sticky trigger overrun flag |

## Verification
The assertions check four things on every cycle. An overrun appears only after an edge that arrived during a running edge-mode sequence. The flag holds until it is cleared. An idle edge-mode controller never answers a software strobe. A level trigger still held at completion restarts at once. The bench scenarios are needed for what depends on history or on the pin path. These are the synchronizer latency and the polarity choice, the default and reprogrammed trigger channel, and scan runs stopping when scan is dropped. They also cover the exact cycle in which a clear and a new overrun collide. Here a behavioural model and a converter stand-in are compared with the outputs on every clock.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

    typedef enum logic [1:0] {
        MODE_SOFT  = 2'd0,
        MODE_EDGE  = 2'd1,
        MODE_LEVEL = 2'd2
    } trig_mode_e;

    typedef struct packed {
        logic en;
        logic level;
        logic pol;
        logic scan;
    } trig_cfg_t;

    typedef struct packed {
        logic edge_hit;
        logic level_on;
    } trig_evt_t;

    function automatic trig_mode_e mode_of(trig_cfg_t c);
        if (!c.en)
            return MODE_SOFT;
        return c.level ? MODE_LEVEL : MODE_EDGE;
    endfunction

    function automatic trig_evt_t classify(logic pol, logic cur, logic prev);
        trig_evt_t e;
        e.edge_hit = pol ? (cur & ~prev) : (~cur & prev);
        e.level_on = pol ? cur : ~cur;
        return e;
    endfunction

endpackage

// File: rtl/adc_trig_front.sv
module adc_trig_front
    import adc_trig_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int DEFAULT_CH  = 7,
    localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_wr,
    input  logic [CH_W-1:0]   sel_data,
    input  logic [NUM_CH-1:0] trig_in,
    input  logic              pol,
    output trig_evt_t         evt
);

    localparam logic [CH_W:0] CH_LIMIT = (CH_W+1)'(NUM_CH);

    logic [CH_W-1:0]        sel_q;
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;
    logic                   raw;
    logic                   cur;

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= CH_W'(DEFAULT_CH);
        else if (sel_wr && ({1'b0, sel_data} < CH_LIMIT))
            sel_q <= sel_data;
    end

    assign raw = trig_in[sel_q];

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= raw;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[SYNC_STAGES-2:0], raw};
            end
        end
    endgenerate

    assign cur = chain_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= cur;
    end

    always_comb evt = classify(pol, cur, prev_q);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_trig_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  trig_cfg_t cfg,
    input  logic      sw_start,
    input  logic      seq_done,
    input  logic      ovr_clr,
    input  trig_evt_t evt,
    output logic      seq_start,
    output logic      busy,
    output logic      ovr_flag
);

    trig_mode_e mode;
    logic busy_q, cont_q, start_q, ovr_q;
    logic free, go, ovr_set;

    assign mode = mode_of(cfg);
    assign free = !busy_q || seq_done;

    always_comb begin
        go      = 1'b0;
        ovr_set = 1'b0;
        unique case (mode)
            MODE_SOFT:  go = (!busy_q && sw_start) ||
                             (busy_q && seq_done && cont_q && cfg.scan);
            MODE_EDGE: begin
                go      = evt.edge_hit && free;
                ovr_set = evt.edge_hit && !free;
            end
            MODE_LEVEL: go = evt.level_on && free;
            default:    go = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            cont_q  <= 1'b0;
            start_q <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            start_q <= go;
            if (go)            busy_q <= 1'b1;
            else if (seq_done) busy_q <= 1'b0;
            if (mode != MODE_SOFT || !cfg.scan) cont_q <= 1'b0;
            else if (go && !busy_q)             cont_q <= 1'b1;
            if (ovr_set)      ovr_q <= 1'b1;
            else if (ovr_clr) ovr_q <= 1'b0;
        end
    end

    assign seq_start = start_q;
    assign busy      = busy_q;
    assign ovr_flag  = ovr_q;

    AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_q) |-> $past(cfg.en && !cfg.level && evt.edge_hit && busy_q && !seq_done)); // R6
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovr_q && !ovr_clr |=> ovr_q); // R10
    AST_EDGE_NO_EXTRA: assert property (@(posedge clk) disable iff (rst)
        cfg.en && !cfg.level && busy_q && !seq_done && evt.edge_hit |=> !start_q && ovr_q); // R6
    AST_SW_IGNORED: assert property (@(posedge clk) disable iff (rst)
        cfg.en && !cfg.level && !evt.edge_hit |=> !start_q); // R9
    AST_LEVEL_RESTART: assert property (@(posedge clk) disable iff (rst)
        cfg.en && cfg.level && evt.level_on && busy_q && seq_done |=> start_q); // R7
    AST_LEVEL_NO_OVR: assert property (@(posedge clk) disable iff (rst)
        cfg.en && cfg.level && !ovr_q && !$past(cfg.en && !cfg.level) |=> !ovr_q); // R8

endmodule

// File: rtl/adc_seq_trigger.sv
module adc_seq_trigger
    import adc_trig_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int DEFAULT_CH  = 7,
    localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_en,
    input  logic              trig_level,
    input  logic              trig_pol,
    input  logic              scan_mode,
    input  logic              sw_start,
    input  logic              sel_wr,
    input  logic [CH_W-1:0]   sel_data,
    input  logic [NUM_CH-1:0] trig_in,
    input  logic              seq_done,
    input  logic              ovr_clr,
    output logic              seq_start,
    output logic              busy,
    output logic              ovr_flag
);

    trig_cfg_t cfg;
    trig_evt_t evt;

    assign cfg = '{en: trig_en, level: trig_level, pol: trig_pol, scan: scan_mode};

    adc_trig_front #(
        .NUM_CH      (NUM_CH),
        .SYNC_STAGES (SYNC_STAGES),
        .DEFAULT_CH  (DEFAULT_CH)
    ) u_front (
        .clk      (clk),
        .rst      (rst),
        .sel_wr   (sel_wr),
        .sel_data (sel_data),
        .trig_in  (trig_in),
        .pol      (trig_pol),
        .evt      (evt)
    );

    adc_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .sw_start  (sw_start),
        .seq_done  (seq_done),
        .ovr_clr   (ovr_clr),
        .evt       (evt),
        .seq_start (seq_start),
        .busy      (busy),
        .ovr_flag  (ovr_flag)
    );

endmodule

// File: tb/adc_seq_trigger_tb.sv
module adc_seq_trigger_tb;

    localparam int NUM_CH  = 8;
    localparam int SYNC    = 2;
    localparam int DEF_CH  = 7;
    localparam int CH_W    = 3;
    localparam int SEQ_LEN = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trig_en = 0, trig_level = 0, trig_pol = 0, scan_mode = 0;
    logic sw_start = 0, sel_wr = 0, seq_done = 0, ovr_clr = 0;
    logic [CH_W-1:0]   sel_data = '0;
    logic [NUM_CH-1:0] trig_in = '0;
    logic seq_start, busy, ovr_flag;

    always #5 clk = ~clk;

    adc_seq_trigger #(.NUM_CH(NUM_CH), .SYNC_STAGES(SYNC), .DEFAULT_CH(DEF_CH)) u_dut (
        .clk(clk), .rst(rst), .trig_en(trig_en), .trig_level(trig_level),
        .trig_pol(trig_pol), .scan_mode(scan_mode), .sw_start(sw_start),
        .sel_wr(sel_wr), .sel_data(sel_data), .trig_in(trig_in),
        .seq_done(seq_done), .ovr_clr(ovr_clr), .seq_start(seq_start),
        .busy(busy), .ovr_flag(ovr_flag)
    );

    int vectors = 0;
    int fails   = 0;
    int n_starts = 0;
    string cur_req = "R1";
    bit started = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp_v, $time);
        end
    endtask

    // behavioural reference: queue of sampled pin values stands for the synchronizer
    bit pins[$];
    int m_sel;
    bit m_busy, m_cont, m_start, m_ovr;

    always @(posedge clk) begin
        bit s, p, hit, on, free, go, oset;
        if (rst) begin
            m_busy = 0; m_cont = 0; m_start = 0; m_ovr = 0; m_sel = DEF_CH;
            pins.delete();
            for (int i = 0; i <= SYNC; i++) pins.push_back(1'b0);
        end else begin
            s = pins[SYNC-1];
            p = pins[SYNC];
            hit = trig_pol ? (s && !p) : (!s && p);
            on  = trig_pol ? s : !s;
            free = !m_busy || seq_done;
            go = 0; oset = 0;
            if (!trig_en)
                go = (!m_busy && sw_start) || (m_busy && seq_done && m_cont && scan_mode);
            else if (!trig_level) begin
                if (hit) begin
                    if (free) go = 1; else oset = 1;
                end
            end else
                go = on && free;
            if (trig_en || !scan_mode) m_cont = 0;
            else if (go && !m_busy)    m_cont = 1;
            if (oset)         m_ovr = 1;
            else if (ovr_clr) m_ovr = 0;
            if (go)            m_busy = 1;
            else if (seq_done) m_busy = 0;
            m_start = go;
            pins.push_front(trig_in[m_sel]);
            void'(pins.pop_back());
            if (sel_wr && sel_data < NUM_CH) m_sel = sel_data;
        end
        started = 1;
    end

    // converter stand-in
    int conv_cnt = 0;
    always @(negedge clk) begin
        seq_done <= 1'b0;
        if (rst) conv_cnt = 0;
        else if (seq_start) conv_cnt = SEQ_LEN;
        else if (conv_cnt != 0) begin
            conv_cnt--;
            if (conv_cnt == 0) seq_done <= 1'b1;
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (started && !finished) begin
            if (seq_start) n_starts++;
            chk(seq_start == m_start, {cur_req, " seq_start"}, seq_start, m_start);
            chk(busy == m_busy, {cur_req, " busy"}, busy, m_busy);
            chk(ovr_flag == m_ovr, {cur_req, " ovr_flag"}, ovr_flag, m_ovr);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_sw();
        sw_start = 1; cyc(1); sw_start = 0;
    endtask

    initial begin
        int base;
        cyc(3);
        rst = 0;
        // R1: reset state
        chk(seq_start == 0 && busy == 0 && ovr_flag == 0, "R1 reset outputs",
            {seq_start, busy, ovr_flag}, 0);
        cyc(2);

        // R2 and R4: one-shot software start, second strobe while busy ignored
        cur_req = "R2"; base = n_starts;
        @(negedge clk); sw_start = 1;
        @(negedge clk); sw_start = 0;
        chk(seq_start == 1, "R2 start one cycle after strobe", seq_start, 1);
        cyc(1);
        cur_req = "R4"; pulse_sw();
        cyc(12);
        chk(n_starts - base == 1, "R4 strobe while busy ignored", n_starts - base, 1);
        chk(busy == 0, "R2 idle after one sequence", busy, 0);

        // R3: scan mode runs back to back until cleared
        cur_req = "R3"; base = n_starts; scan_mode = 1;
        pulse_sw();
        cyc(20);
        chk(n_starts - base >= 4, "R3 continuous sequences", n_starts - base, 4);
        scan_mode = 0;
        cyc(12);
        base = n_starts; cyc(10);
        chk(n_starts - base == 0 && busy == 0, "R3 stops after scan cleared", n_starts - base, 0);

        // R9: software strobe ignored with external trigger on
        cur_req = "R9"; base = n_starts;
        trig_en = 1; trig_level = 0; trig_pol = 1;
        cyc(4); pulse_sw(); cyc(8);
        chk(n_starts - base == 0, "R9 sw_start ignored", n_starts - base, 0);

        // R5 + R1: rising edge on default channel 7, latency SYNC+1
        cur_req = "R5"; base = n_starts;
        trig_in[7] = 1;
        cyc(SYNC);
        chk(seq_start == 0, "R5 no start before sync latency", seq_start, 0);
        cyc(1);
        chk(seq_start == 1, "R5/R1 rising edge on ch7 starts", seq_start, 1);
        cyc(8); trig_in[7] = 0; cyc(10);
        chk(n_starts - base == 1, "R5 one start per rising edge", n_starts - base, 1);

        // R5: falling edge polarity
        base = n_starts; trig_pol = 0; trig_in[7] = 1; cyc(6);
        trig_in[7] = 0; cyc(10); trig_in[7] = 1; cyc(10);
        chk(n_starts - base == 1, "R5 one start per falling edge", n_starts - base, 1);

        // R6: extra edge during sequence
        cur_req = "R6"; trig_pol = 1; trig_in[7] = 0; cyc(6);
        base = n_starts;
        trig_in[7] = 1; cyc(1); trig_in[7] = 0; cyc(1); trig_in[7] = 1; cyc(1); trig_in[7] = 0;
        cyc(12);
        chk(n_starts - base == 1, "R6 no extra start", n_starts - base, 1);
        chk(ovr_flag == 1, "R6 overrun set", ovr_flag, 1);

        // R10: sticky, clear, collision with clear
        cur_req = "R10"; cyc(5);
        chk(ovr_flag == 1, "R10 overrun sticky", ovr_flag, 1);
        ovr_clr = 1; cyc(1); ovr_clr = 0; cyc(1);
        chk(ovr_flag == 0, "R10 cleared by ovr_clr", ovr_flag, 0);
        trig_in[7] = 1; cyc(1); trig_in[7] = 0; cyc(1); trig_in[7] = 1;
        ovr_clr = 1; cyc(SYNC + 1);
        ovr_clr = 0; cyc(1);
        chk(ovr_flag == 1, "R10 overrun beats same-cycle clear", ovr_flag, 1);
        trig_in[7] = 0; cyc(10);
        ovr_clr = 1; cyc(1); ovr_clr = 0; cyc(2);

        // R7 and R8: level high, toggle mid-sequence
        cur_req = "R7"; base = n_starts; trig_level = 1; trig_pol = 1;
        trig_in[7] = 1; cyc(8);
        cur_req = "R8"; trig_in[7] = 0; cyc(1); trig_in[7] = 1; cyc(12);
        chk(n_starts - base >= 4, "R7 repeats while high", n_starts - base, 4);
        chk(ovr_flag == 0, "R8 no overrun in level mode", ovr_flag, 0);
        trig_in[7] = 0; cyc(12);
        base = n_starts; cyc(8);
        chk(n_starts - base == 0, "R7 stops when inactive", n_starts - base, 0);

        // R7: level low polarity
        cur_req = "R7"; trig_in[7] = 1; cyc(2); trig_pol = 0; cyc(4);
        base = n_starts; trig_in[7] = 0; cyc(14); trig_in[7] = 1; cyc(12);
        chk(n_starts - base >= 3, "R7 repeats while low", n_starts - base, 3);

        // R11: select channel 2
        cur_req = "R11"; trig_level = 0; trig_pol = 1; trig_in = '0; cyc(6);
        sel_wr = 1; sel_data = 3'd2; cyc(1); sel_wr = 0; cyc(4);
        base = n_starts;
        trig_in[7] = 1; cyc(8); trig_in[7] = 0; cyc(8);
        chk(n_starts - base == 0, "R11 old channel ignored", n_starts - base, 0);
        trig_in[2] = 1; cyc(8); trig_in[2] = 0; cyc(8);
        chk(n_starts - base == 1, "R11 new channel triggers", n_starts - base, 1);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            vectors++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule